// File: doc/BRIEF.md
# Parallel-Port Key Sequence and Command Detector

This block sits on the peripheral side of a PC-style parallel port. It watches the byte the host drives on the eight data lines and the value on the control lines. When the host writes a fixed seven-byte unlock key, then a command byte, and then pulses the control lines, the block takes the command. One command connects the adapter, another releases it, and a third is accepted without changing anything. Register access and the disk-side behaviour of the adapter belong to other blocks.

While the key is arriving, the block puts identification nibbles on the upper status lines. A host that reads them at the right steps sees the three-nibble value B5Fh, which tells it that the adapter is present. The outputs are a connected flag, a one-cycle command-valid pulse with the command byte, and the 4-bit status nibble. The data lines are sampled on every clock. A new byte is recognised only when the sampled value changes, so a slow host may hold a byte for any number of cycles.

Top module: `keyseq_detect`

## Requirements
- R1: Reset, asserted at any time, at once clears `connected`, `cmd_valid` and `id_nibble` to 0. It also returns matching to the start, so a byte that would have continued an earlier partial key does not raise an identification nibble.
- R2: Data bytes FEh, AAh, 55h, 00h, FFh, 87h, 78h, then a command byte, arm the command. The command is taken only after `host_ctrl` (4 bits) reads 5h and then 4h. Taking it raises `cmd_valid` for exactly one clock with `cmd_byte` equal to the command. Without the 5h-then-4h strobe, no pulse is given.
- R3: Command 20h sets `connected` to 1 and command 30h clears it. `connected` changes only in the cycle in which `cmd_valid` is high.
- R4: Command 00h gives a `cmd_valid` pulse with `cmd_byte` 00h and leaves `connected` unchanged.
- R5: Any other command byte gives no pulse and no change to `connected`, and matching restarts from the beginning of the key.
- R6: `id_nibble` reads Bh once FFh has been matched as the fifth key byte, and 5h once 87h has been matched as the sixth. It reads Fh while an armed command sees the 5h strobe level. It reads 0h at all other times.
- R7: A data byte that is not the expected next key byte returns matching to the start. If that byte is FEh, it is counted as the first key byte.
- R8: The data lines are sampled on every clock. A byte counts once, when the sampled value changes. Holding a value for any number of cycles does not advance matching again.
- R9: A change of the data byte after the command byte and before the strobe completes abandons the command, so no pulse is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_data | input | 8 | Host-driven parallel data lines |
| host_ctrl | input | CTRL_W | Host-driven control lines |
| connected | output | 1 | Adapter selected by the host |
| cmd_valid | output | 1 | One-cycle pulse when a command is taken |
| cmd_byte | output | 8 | Command byte of the last pulse |
| id_nibble | output | 4 | Value for the upper status lines |

## Verification
The bench builds the block with its defaults: a 4-bit control input, strobe levels 5h and 4h, commands 20h, 30h and 00h, identification nibbles B, 5 and F, and a two-stage reset release. These values make the real host sequences reachable. The bench checks select, release and no-op commands, a key broken by a wrong byte and restarted by FEh, and held bytes. It also covers commands abandoned by a data change, an unknown command, an armed command waiting without a strobe, and a reset in the middle of a partial key.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned KEY_LEN = 7;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HELD   = 2'd1,
    PH_STROBE = 2'd2
  } cmd_phase_e;

  // Unlock key, in arrival order (the order is behaviour).
  function automatic logic [BYTE_W-1:0] key_byte(input int unsigned idx);
    logic [BYTE_W-1:0] b;
    case (idx)
      0:       b = 8'hFE;
      1:       b = 8'hAA;
      2:       b = 8'h55;
      3:       b = 8'h00;
      4:       b = 8'hFF;
      5:       b = 8'h87;
      6:       b = 8'h78;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/keyseq_sampler.sv
module keyseq_sampler
  import keyseq_pkg::*;
#(
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] data_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [BYTE_W-1:0] data_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              new_byte_o
);

  logic [BYTE_W-1:0] cur_q, cur_d;
  logic [BYTE_W-1:0] last_q, last_d;
  logic [CTRL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    cur_d  = data_in;
    last_d = cur_q;
    ctl_d  = ctrl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
      ctl_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      last_q <= last_d;
      ctl_q  <= ctl_d;
    end
  end

  assign data_o     = cur_q;
  assign ctrl_o     = ctl_q;
  assign new_byte_o = (cur_q != last_q);

endmodule

// File: rtl/keyseq_match.sv
module keyseq_match
  import keyseq_pkg::*;
#(
  localparam int unsigned POS_W = $clog2(KEY_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_byte_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              take_o,
  output logic [BYTE_W-1:0] cmd_o
);

  localparam logic [POS_W-1:0] POS_END = POS_W'(KEY_LEN);

  logic [KEY_LEN-1:0] hit;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic               pos_en;
  logic               take;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_hit
    assign hit[g] = (data_i == key_byte(g));
  end

  always_comb begin
    pos_d  = pos_q;
    pos_en = 1'b0;
    take   = 1'b0;
    if (new_byte_i) begin
      pos_en = 1'b1;
      if (pos_q == POS_END) begin
        take  = 1'b1;
        pos_d = '0;
      end else if (hit[pos_q]) begin
        pos_d = pos_q + POS_W'(1);
      end else if (hit[0]) begin
        pos_d = POS_W'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o  = pos_q;
  assign take_o = take;
  assign cmd_o  = data_i;

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !new_byte_i |=> $stable(pos_q)); // R8

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (new_byte_i && pos_q < POS_END) |=> (pos_q <= POS_W'(1) || pos_q == $past(pos_q) + POS_W'(1))); // R7

endmodule

// File: rtl/keyseq_cmd.sv
module keyseq_cmd
  import keyseq_pkg::*;
#(
  parameter int unsigned     CTRL_W      = 4,
  parameter logic [CTRL_W-1:0] CTRL_REST   = 4'h4,
  parameter logic [CTRL_W-1:0] CTRL_STROBE = 4'h5,
  parameter logic [BYTE_W-1:0] CMD_SEL     = 8'h20,
  parameter logic [BYTE_W-1:0] CMD_DESEL   = 8'h30,
  parameter logic [BYTE_W-1:0] CMD_NOP     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_byte_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_phase_e        phase_o,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              conn_o
);

  cmd_phase_e        phase_q, phase_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              held_en;
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              out_en;
  logic              conn_q, conn_d;
  logic              legal;

  assign legal = (cmd_i == CMD_SEL) || (cmd_i == CMD_DESEL) || (cmd_i == CMD_NOP);

  always_comb begin
    phase_d = phase_q;
    held_d  = held_q;
    held_en = 1'b0;
    valid_d = 1'b0;
    out_d   = out_q;
    out_en  = 1'b0;
    conn_d  = conn_q;
    case (phase_q)
      PH_IDLE: begin
        if (take_i && legal) begin
          phase_d = PH_HELD;
          held_d  = cmd_i;
          held_en = 1'b1;
        end
      end
      PH_HELD: begin
        if (new_byte_i)                phase_d = PH_IDLE;
        else if (ctrl_i == CTRL_STROBE) phase_d = PH_STROBE;
      end
      PH_STROBE: begin
        if (new_byte_i) begin
          phase_d = PH_IDLE;
        end else if (ctrl_i == CTRL_REST) begin
          phase_d = PH_IDLE;
          valid_d = 1'b1;
          out_d   = held_q;
          out_en  = 1'b1;
          if (held_q == CMD_SEL)        conn_d = 1'b1;
          else if (held_q == CMD_DESEL) conn_d = 1'b0;
        end else if (ctrl_i != CTRL_STROBE) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      held_q  <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
      conn_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      conn_q  <= conn_d;
      if (held_en) held_q <= held_d;
      if (out_en)  out_q  <= out_d;
    end
  end

  assign phase_o = phase_q;
  assign valid_o = valid_q;
  assign byte_o  = out_q;
  assign conn_o  = conn_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R2

  AST_CONN_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conn_q) |-> valid_q); // R3

  AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && out_q == CMD_NOP) |-> $stable(conn_q)); // R4

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (out_q == CMD_SEL || out_q == CMD_DESEL || out_q == CMD_NOP)); // R5

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && new_byte_i) |=> !valid_q); // R9

endmodule

// File: rtl/keyseq_detect.sv
module keyseq_detect
  import keyseq_pkg::*;
#(
  parameter int unsigned       CTRL_W      = 4,
  parameter logic [CTRL_W-1:0] CTRL_REST   = 4'h4,
  parameter logic [CTRL_W-1:0] CTRL_STROBE = 4'h5,
  parameter logic [BYTE_W-1:0] CMD_SEL     = 8'h20,
  parameter logic [BYTE_W-1:0] CMD_DESEL   = 8'h30,
  parameter logic [BYTE_W-1:0] CMD_NOP     = 8'h00,
  parameter int unsigned       STAT_W      = 4,
  parameter logic [STAT_W-1:0] ID_FIRST    = 4'hB,
  parameter logic [STAT_W-1:0] ID_SECOND   = 4'h5,
  parameter logic [STAT_W-1:0] ID_THIRD    = 4'hF,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] host_data,
  input  logic [CTRL_W-1:0] host_ctrl,
  output logic              connected,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [STAT_W-1:0] id_nibble
);

  localparam int unsigned      POS_W      = $clog2(KEY_LEN + 1);
  localparam logic [POS_W-1:0] POS_ID_ONE = POS_W'(KEY_LEN - 2);
  localparam logic [POS_W-1:0] POS_ID_TWO = POS_W'(KEY_LEN - 1);

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic [BYTE_W-1:0] smp_data;
  logic [CTRL_W-1:0] smp_ctrl;
  logic              new_byte;
  logic [POS_W-1:0]  pos;
  logic              take;
  logic [BYTE_W-1:0] cmd_cand;
  cmd_phase_e        phase;

  keyseq_sampler #(.CTRL_W(CTRL_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .data_in    (host_data),
    .ctrl_in    (host_ctrl),
    .data_o     (smp_data),
    .ctrl_o     (smp_ctrl),
    .new_byte_o (new_byte)
  );

  keyseq_match u_match (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .new_byte_i (new_byte),
    .data_i     (smp_data),
    .pos_o      (pos),
    .take_o     (take),
    .cmd_o      (cmd_cand)
  );

  keyseq_cmd #(
    .CTRL_W      (CTRL_W),
    .CTRL_REST   (CTRL_REST),
    .CTRL_STROBE (CTRL_STROBE),
    .CMD_SEL     (CMD_SEL),
    .CMD_DESEL   (CMD_DESEL),
    .CMD_NOP     (CMD_NOP)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .new_byte_i (new_byte),
    .ctrl_i     (smp_ctrl),
    .take_i     (take),
    .cmd_i      (cmd_cand),
    .phase_o    (phase),
    .valid_o    (cmd_valid),
    .byte_o     (cmd_byte),
    .conn_o     (connected)
  );

  always_comb begin
    id_nibble = '0;
    if (phase == PH_STROBE)      id_nibble = ID_THIRD;
    else if (pos == POS_ID_ONE)  id_nibble = ID_FIRST;
    else if (pos == POS_ID_TWO)  id_nibble = ID_SECOND;
  end

  AST_ID_THIRD_ARMED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_nibble == ID_THIRD) |-> !cmd_valid); // R6

endmodule

// File: tb/tb_keyseq_detect.sv
`timescale 1ns/1ps
module tb_keyseq_detect;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] host_data;
  logic [3:0] host_ctrl;
  logic       connected, cmd_valid;
  logic [7:0] cmd_byte;
  logic [3:0] id_nibble;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [7:0] last_cmd = 8'h00;

  always #4 clk = ~clk;

  keyseq_detect dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_data (host_data),
    .host_ctrl (host_ctrl),
    .connected (connected),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .id_nibble (id_nibble)
  );

  // Pulse counter: counts falling edges with cmd_valid high, so a pulse
  // wider than one clock shows up as an extra count.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmd_valid === 1'b1) begin
      pulses   = pulses + 1;
      last_cmd = cmd_byte;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [3:0] c);
    @(negedge clk);
    host_data = d;
    host_ctrl = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_key();
    apply(8'hFE, 4'h4); apply(8'hAA, 4'h4); apply(8'h55, 4'h4);
    apply(8'h00, 4'h4); apply(8'hFF, 4'h4); apply(8'h87, 4'h4);
    apply(8'h78, 4'h4);
  endtask

  function automatic logic [20:0] vec(input logic [7:0] d, input logic [3:0] c,
                                      input logic [3:0] s, input logic k, input logic [3:0] p);
    return {d, c, s, k, p};
  endfunction

  // data, ctrl, expected id nibble, expected connected, expected pulse total
  localparam logic [20:0] TBL [48] = '{
    // select with 20h (R2 R3 R6)
    vec(8'hFE,4'h4,4'h0,1'b0,4'd0), vec(8'hAA,4'h4,4'h0,1'b0,4'd0),
    vec(8'h55,4'h4,4'h0,1'b0,4'd0), vec(8'h00,4'h4,4'h0,1'b0,4'd0),
    vec(8'hFF,4'h4,4'hB,1'b0,4'd0), vec(8'h87,4'h4,4'h5,1'b0,4'd0),
    vec(8'h78,4'h4,4'h0,1'b0,4'd0), vec(8'h20,4'h4,4'h0,1'b0,4'd0),
    vec(8'h20,4'h5,4'hF,1'b0,4'd0), vec(8'h20,4'h4,4'h0,1'b1,4'd1),
    vec(8'hFF,4'h4,4'h0,1'b1,4'd1),
    // wrong byte 11h then FE restart, release with 30h (R7 R3)
    vec(8'hFE,4'h4,4'h0,1'b1,4'd1), vec(8'hAA,4'h4,4'h0,1'b1,4'd1),
    vec(8'h55,4'h4,4'h0,1'b1,4'd1), vec(8'h11,4'h4,4'h0,1'b1,4'd1),
    vec(8'hFE,4'h4,4'h0,1'b1,4'd1), vec(8'hAA,4'h4,4'h0,1'b1,4'd1),
    vec(8'h55,4'h4,4'h0,1'b1,4'd1), vec(8'h00,4'h4,4'h0,1'b1,4'd1),
    vec(8'hFF,4'h4,4'hB,1'b1,4'd1), vec(8'h87,4'h4,4'h5,1'b1,4'd1),
    vec(8'h78,4'h4,4'h0,1'b1,4'd1), vec(8'h30,4'h4,4'h0,1'b1,4'd1),
    vec(8'h30,4'h5,4'hF,1'b1,4'd1), vec(8'h30,4'h4,4'h0,1'b0,4'd2),
    // no-op 00h (R4)
    vec(8'hFF,4'h4,4'h0,1'b0,4'd2), vec(8'hFE,4'h4,4'h0,1'b0,4'd2),
    vec(8'hAA,4'h4,4'h0,1'b0,4'd2), vec(8'h55,4'h4,4'h0,1'b0,4'd2),
    vec(8'h00,4'h4,4'h0,1'b0,4'd2), vec(8'hFF,4'h4,4'hB,1'b0,4'd2),
    vec(8'h87,4'h4,4'h5,1'b0,4'd2), vec(8'h78,4'h4,4'h0,1'b0,4'd2),
    vec(8'h00,4'h4,4'h0,1'b0,4'd2), vec(8'h00,4'h5,4'hF,1'b0,4'd2),
    vec(8'h00,4'h4,4'h0,1'b0,4'd3),
    // FE arriving in place of 55h counts as a fresh first byte (R7)
    vec(8'hFE,4'h4,4'h0,1'b0,4'd3), vec(8'hAA,4'h4,4'h0,1'b0,4'd3),
    vec(8'hFE,4'h4,4'h0,1'b0,4'd3), vec(8'hAA,4'h4,4'h0,1'b0,4'd3),
    vec(8'h55,4'h4,4'h0,1'b0,4'd3), vec(8'h00,4'h4,4'h0,1'b0,4'd3),
    vec(8'hFF,4'h4,4'hB,1'b0,4'd3), vec(8'h87,4'h4,4'h5,1'b0,4'd3),
    vec(8'h78,4'h4,4'h0,1'b0,4'd3), vec(8'h20,4'h4,4'h0,1'b0,4'd3),
    vec(8'h20,4'h5,4'hF,1'b0,4'd3), vec(8'h20,4'h4,4'h0,1'b1,4'd4)
  };

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    host_data = 8'h00;
    host_ctrl = 4'h4;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: state after reset
    check("R1 connected", connected, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 id_nibble", id_nibble, 0);

    for (int i = 0; i < 48; i++) begin
      apply(TBL[i][20:13], TBL[i][12:9]);
      check($sformatf("R6 id_nibble step %0d", i), id_nibble, TBL[i][8:5]);
      check($sformatf("R3 connected step %0d", i), connected, TBL[i][4]);
      check($sformatf("R2 pulses step %0d", i), pulses, TBL[i][3:0]);
    end
    check("R2 cmd_byte after select", last_cmd, 8'h20);

    // R8: holding a key byte does not advance matching
    apply(8'hFF, 4'h4);
    apply(8'hFE, 4'h4); apply(8'hAA, 4'h4); apply(8'h55, 4'h4);
    apply(8'h00, 4'h4); apply(8'hFF, 4'h4);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R8 held FF keeps B", id_nibble, 4'hB);
    apply(8'h87, 4'h4);
    check("R8 next byte after hold", id_nibble, 4'h5);

    // R9: data change before the strobe abandons the command
    apply(8'h78, 4'h4); apply(8'h20, 4'h4);
    apply(8'h21, 4'h4); apply(8'h21, 4'h5);
    check("R9 no strobe status after abort", id_nibble, 0);
    apply(8'h21, 4'h4);
    check("R9 no pulse after abort", pulses, 4);
    check("R9 connected kept", connected, 1);

    // R9: data change while the strobe level is high
    send_key();
    apply(8'h30, 4'h4); apply(8'h30, 4'h5);
    check("R6 strobe status", id_nibble, 4'hF);
    apply(8'h31, 4'h5);
    check("R9 abort during strobe status", id_nibble, 0);
    apply(8'h31, 4'h4);
    check("R9 no pulse from abort during strobe", pulses, 4);
    check("R9 connected kept after strobe abort", connected, 1);

    // R5: unknown command byte
    send_key();
    apply(8'h44, 4'h4); apply(8'h44, 4'h5);
    check("R5 unknown cmd no strobe status", id_nibble, 0);
    apply(8'h44, 4'h4);
    check("R5 unknown cmd no pulse", pulses, 4);
    check("R5 unknown cmd connected kept", connected, 1);

    // R2: armed command waits for the strobe
    send_key();
    apply(8'h30, 4'h4);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R2 no pulse without strobe", pulses, 4);
    check("R2 connected kept without strobe", connected, 1);
    apply(8'h30, 4'h5); apply(8'h30, 4'h4);
    check("R2 late strobe pulse", pulses, 5);
    check("R2 cmd_byte release", last_cmd, 8'h30);
    check("R3 released", connected, 0);

    // R1: reset while connected and part-way through a key
    apply(8'hFF, 4'h4);
    send_key();
    apply(8'h20, 4'h4); apply(8'h20, 4'h5); apply(8'h20, 4'h4);
    check("R3 reselected", connected, 1);
    apply(8'hFE, 4'h4); apply(8'hAA, 4'h4); apply(8'h55, 4'h4);
    apply(8'h00, 4'h4); apply(8'hFF, 4'h4);
    check("R6 B before reset", id_nibble, 4'hB);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async connected", connected, 0);
    check("R1 async id_nibble", id_nibble, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 cmd_valid after reset", cmd_valid, 0);
    apply(8'h87, 4'h4);
    check("R1 partial key forgotten", id_nibble, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule